// File: doc/BRIEF.md
# Load/Store Lane Steering Unit

This block sits between a 32-bit core and a 32-bit little-endian data bus and does the byte-lane work for memory accesses. On the store side it is combinational. It takes the register value, the access size and the two low address bits, and returns a bus write word in which the stored item is copied into every lane it could occupy. It also returns one write strobe per byte lane and an alignment-error flag for odd halfword addresses.

On the load side, the size, the signed flag and the low address bits are captured in the cycle the load request is issued. In the following cycle the read word arrives from the bus, and the block moves the addressed byte or halfword down to bit 0. It then zero- or sign-extends that item to 32 bits and marks the result valid. Word accesses pass through both paths unchanged.

Size encoding on `req_size`: 2'b00 byte, 2'b01 halfword, 2'b10 word; 2'b11 is treated as word.

Top module: `lsu_align`

## Requirements
- R1: On a byte load, byte lane `addr[1:0]` of the read word (lane n = bits 8n+7:8n) appears in `ld_result[7:0]`.
- R2: On a halfword load, `addr[1]` selects the low (0) or high (1) half of the read word, which appears in `ld_result[15:0]`. `addr[0]` has no effect on the load result.
- R3: Byte and halfword loads are sign-extended to 32 bits when the captured signed flag is 1 and zero-extended when it is 0. The flag has no effect on word loads.
- R4: A word load (size 2'b10 or 2'b11) returns the read word unchanged, whatever the address bits.
- R5: A halfword store drives `req_wdata[15:0]` onto both `bus_wdata[15:0]` and `bus_wdata[31:16]`.
- R6: A byte store drives `req_wdata[7:0]` onto all four byte lanes of `bus_wdata`.
- R7: A word store drives `req_wdata` onto `bus_wdata` unchanged.
- R8: `bus_wstrb[n]` enables byte lane n. When a write is requested, a byte write enables only lane `addr[1:0]`. A halfword write enables 4'b0011 if `addr[1]` is 0 and 4'b1100 if it is 1. A word write enables 4'b1111. Without a write request the strobes are 4'b0000.
- R9: `align_err` is 1, in the same cycle, exactly when a request is valid, its size is halfword and `addr[0]` is 1.
- R10: Load attributes are captured on the clock edge at which `req_valid`=1 and `req_write`=0. `ld_valid` is 1 exactly in the following cycle, and in that cycle `ld_result` is formed from `rd_data` using those attributes. The attributes are held until the next load request.
- R11: After a synchronous active-low reset, `ld_valid` is 0 and the held attributes are word/unsigned, so `ld_result` equals `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 2 | Low address bits of the access |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend a loaded byte or halfword |
| req_wdata | input | 32 | Register value to store |
| bus_wdata | output | 32 | Lane-replicated write word |
| bus_wstrb | output | 4 | Per-byte-lane write enables |
| align_err | output | 1 | Odd halfword address on a request |
| rd_data | input | 32 | Read word from the bus, one cycle after a load request |
| ld_result | output | 32 | Right-justified, extended load value |
| ld_valid | output | 1 | Load result valid this cycle |

## Verification
The bench targets four kinds of corner case. The first is loads from every lane with the top bit of the item set, where a wrong extension would leave zeros or ones in the upper bits. The second is halfword accesses with `addr[0]` set, where a design that honoured bit 0 would take a misplaced half or the wrong strobes, or would miss the error flag. The third is back-to-back loads with differing attributes, where a design that did not register them at request time would steer the returning word with the next request's size. The fourth is stores of every size, where a shifting rather than a replicating design would leave lanes zero, and reserved size 2'b11, which a careless decode would treat as byte or halfword.

// File: rtl/lsu_align_pkg.sv
// Shared types for the load/store lane steering unit.
// Assumes a little-endian bus made of 8-bit lanes.
package lsu_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Load attributes held between request and returning data
    typedef struct packed {
        logic [1:0] addr;
        acc_size_e  size;
        logic       sgn;
    } ld_attr_t;

endpackage

// File: rtl/lsu_store_fmt.sv
// Store formatter: copies the stored item into every lane of the bus word
// and builds the per-lane write strobes and the halfword alignment flag.
// Purely combinational; assumes four 8-bit lanes and little-endian order.
module lsu_store_fmt
    import lsu_align_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [$clog2(LANES)-1:0] req_addr,
    input  acc_size_e               req_size,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    output logic [LANES*LANE_W-1:0] bus_wdata,
    output logic [LANES-1:0]        bus_wstrb,
    output logic                    align_err
);
    localparam int BUS_W = LANES * LANE_W;
    localparam int OFF_W = $clog2(LANES);

    logic [BUS_W-1:0] byte_rep;
    logic [BUS_W-1:0] half_rep;
    logic [LANES-1:0] strb_byte;
    logic [LANES-1:0] strb_half;
    logic             do_write;

    assign do_write = req_valid && req_write;

    // Per-lane replication patterns and strobe candidates
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_rep[g*LANE_W +: LANE_W] = req_wdata[LANE_W-1:0];
        assign half_rep[g*LANE_W +: LANE_W] = req_wdata[(g%2)*LANE_W +: LANE_W];
        assign strb_byte[g] = (req_addr == OFF_W'(g));
        assign strb_half[g] = (req_addr[OFF_W-1:1] == (OFF_W-1)'(g/2));
    end

    // Select write word and strobes by access size
    always_comb begin
        unique case (req_size)
            SZ_BYTE: begin
                bus_wdata = byte_rep;
                bus_wstrb = do_write ? strb_byte : '0;
            end
            SZ_HALF: begin
                bus_wdata = half_rep;
                bus_wstrb = do_write ? strb_half : '0;
            end
            default: begin
                bus_wdata = req_wdata;
                bus_wstrb = do_write ? '1 : '0;
            end
        endcase
    end

    // Flag an odd halfword address on any valid request
    assign align_err = req_valid && (req_size == SZ_HALF) && req_addr[0];

    AST_BYTE_STRB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && req_size == SZ_BYTE) |-> ($countones(bus_wstrb) == 1)); // R8
    AST_NO_STRB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !do_write |-> (bus_wstrb == '0)); // R8
    AST_BYTE_REPL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == SZ_BYTE) |-> (bus_wdata[BUS_W-1:LANE_W] == {(LANES-1){bus_wdata[LANE_W-1:0]}})); // R6
    AST_HALF_REPL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == SZ_HALF) |-> (bus_wdata[BUS_W-1:BUS_W/2] == bus_wdata[BUS_W/2-1:0])); // R5
    AST_ERR_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (req_size == SZ_HALF && bus_wstrb != 4'b0110)); // R9

endmodule

// File: rtl/lsu_load_ctl.sv
// Load attribute register: captures size, signed flag and low address bits
// when a load is requested and raises the valid marker for the next cycle.
// Assumes read data returns exactly one cycle after the request.
module lsu_load_ctl
    import lsu_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFF_W-1:0] req_addr,
    input  acc_size_e        req_size,
    input  logic             req_signed,
    output ld_attr_t         attr_q,
    output logic             ld_valid
);
    logic take;

    assign take = req_valid && !req_write;

    // Hold attributes of the most recent load request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q   <= '{addr: '0, size: SZ_WORD, sgn: 1'b0};
            ld_valid <= 1'b0;
        end else begin
            ld_valid <= take;
            if (take) begin
                attr_q <= '{addr: req_addr, size: req_size, sgn: req_signed};
            end
        end
    end

    AST_LD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ld_valid); // R10
    AST_ATTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && rst_n && $past(rst_n)) |=> $stable(attr_q)); // R10

endmodule

// File: rtl/lsu_load_ext.sv
// Load extractor: moves the addressed byte or halfword of the read word
// down to bit 0 and zero- or sign-extends it; words pass unchanged.
// Assumes four 8-bit lanes, little-endian, attributes already registered.
module lsu_load_ext
    import lsu_align_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  ld_attr_t                attr,
    input  logic                    ld_valid,
    input  logic [LANES*LANE_W-1:0] rd_data,
    output logic [LANES*LANE_W-1:0] ld_result
);
    localparam int BUS_W  = LANES * LANE_W;
    localparam int HALF_W = 2 * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    logic [LANE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic [OFF_W-2:0]  half_idx;

    assign half_idx = attr.addr[OFF_W-1:1];

    // Pick the addressed byte and halfword
    always_comb begin
        sel_byte = rd_data[int'(attr.addr) * LANE_W +: LANE_W];
        sel_half = rd_data[int'(half_idx) * HALF_W +: HALF_W];
    end

    // Right-justify and extend by size and signed flag
    always_comb begin
        unique case (attr.size)
            SZ_BYTE: ld_result = {{(BUS_W-LANE_W){attr.sgn & sel_byte[LANE_W-1]}}, sel_byte};
            SZ_HALF: ld_result = {{(BUS_W-HALF_W){attr.sgn & sel_half[HALF_W-1]}}, sel_half};
            default: ld_result = rd_data;
        endcase
    end

    AST_UNSIGNED_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && attr.size == SZ_BYTE && !attr.sgn) |-> (ld_result[BUS_W-1:LANE_W] == '0)); // R3
    AST_SIGNED_HALF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && attr.size == SZ_HALF && attr.sgn)
        |-> (ld_result[BUS_W-1:HALF_W] == {(BUS_W-HALF_W){ld_result[HALF_W-1]}})); // R3
    AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (attr.size == SZ_WORD || attr.size == SZ_RSVD)) |-> (ld_result == rd_data)); // R4

endmodule

// File: rtl/lsu_align.sv
// Top of the load/store lane steering unit: combinational store formatting,
// and a load path whose steering attributes are registered at request time
// so they line up with read data returning one cycle later.
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_addr,
    input  logic [1:0]  req_size,
    input  logic        req_signed,
    input  logic [31:0] req_wdata,
    output logic [31:0] bus_wdata,
    output logic [3:0]  bus_wstrb,
    output logic        align_err,
    input  logic [31:0] rd_data,
    output logic [31:0] ld_result,
    output logic        ld_valid
);
    localparam int OFF_W = $clog2(LANES);

    acc_size_e size_e;
    ld_attr_t  attr_q;

    assign size_e = acc_size_e'(req_size);

    lsu_store_fmt #(.LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (size_e),
        .req_wdata (req_wdata),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .align_err (align_err)
    );

    lsu_load_ctl #(.OFF_W(OFF_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (size_e),
        .req_signed (req_signed),
        .attr_q     (attr_q),
        .ld_valid   (ld_valid)
    );

    lsu_load_ext #(.LANE_W(LANE_W), .LANES(LANES)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .attr      (attr_q),
        .ld_valid  (ld_valid),
        .rd_data   (rd_data),
        .ld_result (ld_result)
    );

endmodule

// File: tb/tb_lsu_align.sv
// Bench: fixed-seed random requests plus directed corners, checked against
// bench-side models of the requirements.
module tb_lsu_align;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_signed;
    logic [1:0]  req_addr, req_size;
    logic [31:0] req_wdata, rd_data;
    logic [31:0] bus_wdata, ld_result;
    logic [3:0]  bus_wstrb;
    logic        align_err, ld_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model of held load attributes
    logic [1:0] m_addr = 2'd0;
    logic [1:0] m_size = 2'b10;
    logic       m_sgn  = 1'b0;
    logic       m_vld  = 1'b0;

    always #2.5 clk = ~clk;

    lsu_align dut (.*);

    function automatic logic [31:0] exp_store(logic [1:0] sz, logic [31:0] d);
        if (sz == 2'b00) return {4{d[7:0]}};
        if (sz == 2'b01) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [3:0] exp_strb(logic v, logic w, logic [1:0] sz, logic [1:0] a);
        if (!(v && w)) return 4'b0000;
        if (sz == 2'b00) return 4'b0001 << a;
        if (sz == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_load(logic [1:0] sz, logic [1:0] a, logic s, logic [31:0] r);
        logic [7:0]  b;
        logic [15:0] h;
        b = r[a*8 +: 8];
        h = a[1] ? r[31:16] : r[15:0];
        if (sz == 2'b00) return {{24{s & b[7]}}, b};
        if (sz == 2'b01) return {{16{s & h[15]}}, h};
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check shortly after, model updates at posedge
    task automatic step(logic v, logic w, logic [1:0] a, logic [1:0] sz, logic s,
                        logic [31:0] wd, logic [31:0] rd);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = sz;
        req_signed = s; req_wdata = wd; rd_data = rd;
        #1;
        check(sz == 2'b00 ? "R6 byte store" : sz == 2'b01 ? "R5 half store" : "R7 word store",
              bus_wdata, exp_store(sz, wd));
        check("R8 strobes", {28'd0, bus_wstrb}, {28'd0, exp_strb(v, w, sz, a)});
        check("R9 align_err", {31'd0, align_err}, {31'd0, v && sz == 2'b01 && a[0]});
        check("R10 ld_valid", {31'd0, ld_valid}, {31'd0, m_vld});
        check(m_size == 2'b00 ? "R1/R3 byte load" : m_size == 2'b01 ? "R2/R3 half load" : "R4 word load",
              ld_result, exp_load(m_size, m_addr, m_sgn, rd));
        @(posedge clk);
        m_vld = v && !w;
        if (v && !w) begin
            m_addr = a; m_size = sz; m_sgn = s;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 1'b0;
        req_valid = 0; req_write = 0; req_addr = 0; req_size = 0;
        req_signed = 0; req_wdata = 0; rd_data = 32'hA5C3_0F81;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 ld_valid after reset", {31'd0, ld_valid}, 32'd0);
        check("R11 ld_result passes rd_data", ld_result, rd_data);
        rst_n = 1'b1;

        // Directed: signed/unsigned byte loads from every lane (R1, R3)
        for (int l = 0; l < 4; l++) begin
            step(1, 0, 2'(l), 2'b00, 1, 32'h0, 32'h0);
            step(1, 0, 2'(l), 2'b00, 0, 32'h0, 32'h80FF_7F81);
        end
        step(0, 0, 0, 0, 0, 0, 32'h80FF_7F81);
        // Directed: halfword loads with odd addresses (R2, R3, R9)
        for (int a = 0; a < 4; a++) begin
            step(1, 0, 2'(a), 2'b01, 1, 0, 32'h1234_5678);
            step(1, 0, 2'(a), 2'b01, 0, 0, 32'h8001_F00F);
        end
        // Directed: word loads including reserved size with signed flag (R3, R4)
        step(1, 0, 2'd3, 2'b10, 1, 0, 32'h8001_F00F);
        step(1, 0, 2'd1, 2'b11, 1, 0, 32'hFFFF_0000);
        // Directed: stores of every size and address (R5..R9)
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 4; s++) begin
                step(1, 1, 2'(a), 2'(s), 0, 32'hDEAD_BE8F, 32'hFFFF_0000);
            end
        end
        // Held attributes across idle cycles (R10)
        step(1, 0, 2'd2, 2'b00, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 32'h0080_0000);
        step(0, 1, 1, 2'b00, 0, 0, 32'h00FF_0000);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            step(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
                 $urandom, $urandom);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule